// File: doc/BRIEF.md
# Extended interrupt cause and mask controller

This block gathers hardware event pulses from a network controller into a cause register. It gates them with a mask register and raises interrupt requests towards the host. Software reaches six registers over a simple single-cycle bus: the cause register itself, a cause-set port, separate write-one ports that set and clear mask bits, an auto-clear enable and an auto-mask enable. The cause register reads as clear-on-read and writes as write-one-to-clear. Because the set and clear ports take only the bits written as 1, a driver never needs a read-modify-write to change one mask bit.

A mode input selects how requests leave the block. In message mode, each bit has its own output that pulses for one cycle when that bit becomes pending. Such a pulse can also drop the bit's cause and its mask, when the two enable registers ask for that. In legacy mode, one level output shows whether any unmasked cause is pending. Reading or clearing the cause register then masks the bits selected for auto-masking, and a cause-set write unmasks them again.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After a synchronous reset, the cause, mask, auto-clear enable and auto-mask enable registers are all 0, and vec_irq, line_irq and bus_rdata are 0.
- R2: A 1 on evt[i] sets cause bit i at the next clock edge whatever mask bit i holds. The bit stays set until a clear acts on it.
- R3: A write to address 1 (cause set) sets every cause bit whose wdata bit is 1. Bits written as 0 keep their value.
- R4: A write to address 2 sets the mask bits written as 1, and a write to address 3 clears the mask bits written as 1. Zero bits leave the mask unchanged. A read of address 2 returns the mask.
- R5: A read of address 0 returns the cause value and clears every cause bit that read as 1. A write to address 0 clears the cause bits written as 1.
- R6: An event on a cause bit wins over a software or automatic clear of that bit in the same cycle, so the bit ends up set.
- R7: In message mode (msg_mode=1), vec_irq[i] is high for exactly one cycle. That cycle is the one following the first cycle in which cause bit i and mask bit i are both 1. In this mode line_irq is 0.
- R8: In legacy mode (msg_mode=0), line_irq equals the OR of (cause AND mask), delayed by one register, and vec_irq stays 0.
- R9: In message mode, a vec_irq pulse on a bit whose auto-clear enable (address 4, read/write) is 1 clears that cause bit at the edge that raises the pulse.
- R10: In message mode, a vec_irq pulse on a bit whose auto-mask enable (address 5, read/write) is 1 clears that mask bit at the edge that raises the pulse.
- R11: In legacy mode, a read of address 0 clears every mask bit whose auto-mask enable is 1. A write to address 0 clears the mask bits that are both written as 1 and auto-mask enabled. A write to address 1 sets those same mask bits. Auto-clear has no effect in legacy mode.
- R12: bus_rdata is registered: it takes the value of the addressed register at the edge that samples bus_rd and then holds it. Addresses 1 and 3 and unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_mode | input | 1 | 1 selects per-bit message pulses, 0 selects the legacy level line |
| evt | input | W | Hardware event pulses, one per cause bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| vec_irq | output | W | Per-bit interrupt pulses in message mode |
| line_irq | output | 1 | Combined interrupt level in legacy mode |

## Verification
The bench drives an event into a bit in the same cycle that software clears it, by a write-one or by a clear-on-read. A design that let the clear win would silently lose that interrupt. It checks that a message pulse lasts a single cycle and that it drops exactly the cause and mask bits enabled for auto-action. An edge detector that was missing or off by one would repeat the interrupt, and wrong enable handling would clear bits that should survive. In legacy mode it checks that auto-clear stays inert while auto-mask follows cause reads, clears and sets, since mixing up the two modes would drop pending causes or leave the line masked.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CAUSE = 3'd0,
    RA_CSET  = 3'd1,
    RA_MSET  = 3'd2,
    RA_MCLR  = 3'd3,
    RA_ACLR  = 3'd4,
    RA_AMSK  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      cause_i,
  input  logic [W-1:0]      mask_i,
  output logic [W-1:0]      cause_w1c_o,
  output logic              cause_rdclr_o,
  output logic [W-1:0]      cause_set_o,
  output logic [W-1:0]      mask_set_o,
  output logic [W-1:0]      mask_clr_o,
  output logic [W-1:0]      aclr_o,
  output logic [W-1:0]      amsk_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] aclr_q, amsk_q, rdata_q;

  assign cause_w1c_o   = (wr_i && addr_i == RA_CAUSE) ? wdata_i : '0;
  assign cause_rdclr_o = rd_i && addr_i == RA_CAUSE;
  assign cause_set_o   = (wr_i && addr_i == RA_CSET) ? wdata_i : '0;
  assign mask_set_o    = (wr_i && addr_i == RA_MSET) ? wdata_i : '0;
  assign mask_clr_o    = (wr_i && addr_i == RA_MCLR) ? wdata_i : '0;
  assign aclr_o        = aclr_q;
  assign amsk_o        = amsk_q;
  assign rdata_o       = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aclr_q  <= '0;
      amsk_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && addr_i == RA_ACLR) aclr_q <= wdata_i;
      if (wr_i && addr_i == RA_AMSK) amsk_q <= wdata_i;
      if (rd_i) begin
        case (addr_i)
          RA_CAUSE: rdata_q <= cause_i;
          RA_MSET:  rdata_q <= mask_i;
          RA_ACLR:  rdata_q <= aclr_q;
          RA_AMSK:  rdata_q <= amsk_q;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  AST_WRONLY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (addr_i == RA_CSET || addr_i == RA_MCLR)) |=> (rdata_o == '0)); // R12
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] w1c_i,
  input  logic         rdclr_i,
  input  logic [W-1:0] sw_set_i,
  input  logic [W-1:0] auto_clr_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q, clr_mask;

  assign clr_mask = w1c_i | (rdclr_i ? cause_q : '0) | auto_clr_i;
  assign cause_o  = cause_q;

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= (cause_q & ~clr_mask) | sw_set_i | evt_i;
  end

  AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i))); // R6
  AST_AUTO_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (auto_clr_i != '0) |=> ((cause_q & $past(auto_clr_i & ~evt_i & ~sw_set_i)) == '0)); // R9
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         msg_mode_i,
  input  logic [W-1:0] amsk_i,
  input  logic [W-1:0] mask_set_i,
  input  logic [W-1:0] mask_clr_i,
  input  logic [W-1:0] cause_set_i,
  input  logic [W-1:0] cause_w1c_i,
  input  logic         rdclr_i,
  input  logic [W-1:0] auto_mask_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, leg_set, leg_clr, set_bits, clr_bits;

  assign leg_set  = msg_mode_i ? '0 : (cause_set_i & amsk_i);
  assign leg_clr  = msg_mode_i ? '0 : (amsk_i & (cause_w1c_i | {W{rdclr_i}}));
  assign set_bits = mask_set_i | leg_set;
  assign clr_bits = mask_clr_i | leg_clr | auto_mask_i;
  assign mask_o   = mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q & ~clr_bits) | set_bits;
  end

  AST_MASK_CLEAR_PORT: assert property (@(posedge clk) disable iff (rst)
    (mask_clr_i != '0) |=> ((mask_q & $past(mask_clr_i)) == '0)); // R4
  AST_LEGACY_READ_MASKS: assert property (@(posedge clk) disable iff (rst)
    (!msg_mode_i && rdclr_i && cause_set_i == '0 && mask_set_i == '0)
      |=> ((mask_q & $past(amsk_i)) == '0)); // R11
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         msg_mode_i,
  input  logic [W-1:0] cause_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] aclr_i,
  input  logic [W-1:0] amsk_i,
  output logic [W-1:0] auto_clr_o,
  output logic [W-1:0] auto_mask_o,
  output logic [W-1:0] vec_irq_o,
  output logic         line_irq_o
);
  logic [W-1:0] pend_q, fire, vec_q;
  logic         line_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign fire[g] = cause_i[g] & mask_i[g] & ~pend_q[g];
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[g] <= 1'b0;
        vec_q[g]  <= 1'b0;
      end else begin
        pend_q[g] <= cause_i[g] & mask_i[g];
        vec_q[g]  <= msg_mode_i & fire[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= !msg_mode_i && ((cause_i & mask_i) != '0);
  end

  assign auto_clr_o  = msg_mode_i ? (fire & aclr_i) : '0;
  assign auto_mask_o = msg_mode_i ? (fire & amsk_i) : '0;
  assign vec_irq_o   = vec_q;
  assign line_irq_o  = line_q;

  AST_VEC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (vec_irq_o != '0) |=> ((vec_irq_o & $past(vec_irq_o)) == '0)); // R7
  AST_LINE_QUIET_IN_MSG: assert property (@(posedge clk) disable iff (rst)
    msg_mode_i |=> !line_irq_o); // R7
  AST_VEC_QUIET_IN_LEGACY: assert property (@(posedge clk) disable iff (rst)
    !msg_mode_i |=> (vec_irq_o == '0)); // R8
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_mode,
  input  logic [W-1:0]      evt,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      vec_irq,
  output logic              line_irq
);
  logic [W-1:0] cause, mask, aclr, amsk;
  logic [W-1:0] cause_w1c, cause_set, mask_set, mask_clr;
  logic [W-1:0] auto_clr, auto_mask;
  logic         cause_rdclr;

  irq_bus_regs #(.W(W)) u_bus (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .cause_i(cause), .mask_i(mask),
    .cause_w1c_o(cause_w1c), .cause_rdclr_o(cause_rdclr), .cause_set_o(cause_set),
    .mask_set_o(mask_set), .mask_clr_o(mask_clr), .aclr_o(aclr), .amsk_o(amsk),
    .rdata_o(bus_rdata)
  );

  irq_cause_reg #(.W(W)) u_cause (
    .clk(clk), .rst(rst), .evt_i(evt), .w1c_i(cause_w1c), .rdclr_i(cause_rdclr),
    .sw_set_i(cause_set), .auto_clr_i(auto_clr), .cause_o(cause)
  );

  irq_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .msg_mode_i(msg_mode), .amsk_i(amsk),
    .mask_set_i(mask_set), .mask_clr_i(mask_clr), .cause_set_i(cause_set),
    .cause_w1c_i(cause_w1c), .rdclr_i(cause_rdclr), .auto_mask_i(auto_mask),
    .mask_o(mask)
  );

  irq_out_gen #(.W(W)) u_out (
    .clk(clk), .rst(rst), .msg_mode_i(msg_mode), .cause_i(cause), .mask_i(mask),
    .aclr_i(aclr), .amsk_i(amsk), .auto_clr_o(auto_clr), .auto_mask_o(auto_mask),
    .vec_irq_o(vec_irq), .line_irq_o(line_irq)
  );
endmodule

// File: tb/irq_cause_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cause_ctrl_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          msg_mode = 1'b0;
  logic [W-1:0]  evt = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata, vec_irq;
  logic          line_irq;

  int total = 0, bad = 0;
  int cyc = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  irq_cause_ctrl #(.W(W)) u_irq_cause_ctrl (
    .clk(clk), .rst(rst), .msg_mode(msg_mode), .evt(evt), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .vec_irq(vec_irq), .line_irq(line_irq)
  );

  // Expected-value model built from the requirement list
  logic [W-1:0] m_cause, m_mask, m_aclr, m_amsk, m_pend, m_rdata, m_vec;
  logic         m_line;

  function automatic logic [W-1:0] f_cause_next(logic [W-1:0] c, logic [W-1:0] gen,
                                                logic [W-1:0] ac);
    logic [W-1:0] clr, st;
    clr = (bus_wr && bus_addr == 3'd0) ? bus_wdata : '0;          // R5
    if (bus_rd && bus_addr == 3'd0) clr = clr | c;                 // R5
    if (msg_mode) clr = clr | (gen & ac);                          // R9
    st = (bus_wr && bus_addr == 3'd1) ? bus_wdata : '0;            // R3
    return (c & ~clr) | st | evt;                                  // R2 R6
  endfunction

  function automatic logic [W-1:0] f_mask_next(logic [W-1:0] m, logic [W-1:0] gen,
                                               logic [W-1:0] am);
    logic [W-1:0] st, clr;
    st  = (bus_wr && bus_addr == 3'd2) ? bus_wdata : '0;           // R4
    clr = (bus_wr && bus_addr == 3'd3) ? bus_wdata : '0;           // R4
    if (!msg_mode) begin                                           // R11
      if (bus_wr && bus_addr == 3'd1) st = st | (bus_wdata & am);
      if (bus_wr && bus_addr == 3'd0) clr = clr | (bus_wdata & am);
      if (bus_rd && bus_addr == 3'd0) clr = clr | am;
    end else begin
      clr = clr | (gen & am);                                      // R10
    end
    return (m & ~clr) | st;
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] pend, gen;
    if (rst) begin
      m_cause <= '0; m_mask <= '0; m_aclr <= '0; m_amsk <= '0;
      m_pend <= '0; m_rdata <= '0; m_vec <= '0; m_line <= 1'b0;
    end else begin
      pend = m_cause & m_mask;
      gen  = pend & ~m_pend;
      m_cause <= f_cause_next(m_cause, gen, m_aclr);
      m_mask  <= f_mask_next(m_mask, gen, m_amsk);
      m_pend  <= pend;
      m_vec   <= msg_mode ? gen : '0;                              // R7 R8
      m_line  <= !msg_mode && (pend != '0);                        // R8
      if (bus_wr && bus_addr == 3'd4) m_aclr <= bus_wdata;
      if (bus_wr && bus_addr == 3'd5) m_amsk <= bus_wdata;
      if (bus_rd) begin                                            // R12
        case (bus_addr)
          3'd0: m_rdata <= m_cause;
          3'd2: m_rdata <= m_mask;
          3'd4: m_rdata <= m_aclr;
          3'd5: m_rdata <= m_amsk;
          default: m_rdata <= '0;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R7 vec_irq vs model", vec_irq, m_vec);
      chk("R8 line_irq vs model", {{(W-1){1'b0}}, line_irq}, {{(W-1){1'b0}}, m_line});
      chk("R12 bus_rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [W-1:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;
    @(negedge clk);
    chk("R1 vec_irq after reset", vec_irq, '0);
    chk("R1 line_irq after reset", {31'd0, line_irq}, '0);
    chk("R1 rdata after reset", bus_rdata, '0);
    rd(3'd2, d); chk("R1 mask after reset", d, '0);
    rd(3'd5, d); chk("R1 auto-mask enable after reset", d, '0);

    // legacy mode
    pulse(32'h8);
    rd(3'd0, d); chk("R2 event latched with mask 0", d, 32'h8);
    rd(3'd0, d); chk("R5 clear on read", d, '0);
    wr(3'd1, 32'h5);
    rd(3'd0, d); chk("R3 cause set write", d, 32'h5);
    wr(3'd1, 32'h5);
    wr(3'd0, 32'h1);
    rd(3'd1, d); chk("R12 write-only address reads 0", d, '0);
    wr(3'd1, 32'h0);
    rd(3'd0, d); chk("R5 write one to clear", d, 32'h4);
    wr(3'd1, 32'h4);
    wr(3'd2, 32'h4);
    @(negedge clk);
    chk("R8 line high with unmasked cause", {31'd0, line_irq}, 32'd1);
    chk("R8 no vec pulse in legacy", vec_irq, '0);
    rd(3'd2, d); chk("R4 mask-set address reads mask", d, 32'h4);
    wr(3'd3, 32'h4);
    @(negedge clk);
    chk("R4 mask clear drops line", {31'd0, line_irq}, '0);
    rd(3'd2, d); chk("R4 mask after clear port", d, '0);

    // event and clear of the same bit in the same cycle
    @(negedge clk);
    evt = 32'h4; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h4;
    @(negedge clk);
    evt = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(3'd0, d); chk("R6 event beats write clear", d, 32'h4);
    @(negedge clk);
    evt = 32'h2; bus_rd = 1'b1; bus_addr = 3'd0;
    @(negedge clk);
    evt = '0; bus_rd = 1'b0;
    rd(3'd0, d); chk("R6 event beats read clear", d, 32'h2);

    // legacy auto-mask
    wr(3'd5, 32'h10);
    wr(3'd1, 32'h10);
    rd(3'd2, d); chk("R11 cause-set write sets auto-masked bit", d, 32'h10);
    rd(3'd0, d); chk("R5 read returns cause", d, 32'h10);
    rd(3'd2, d); chk("R11 cause read clears auto-masked mask", d, '0);
    wr(3'd2, 32'h30);
    wr(3'd0, 32'h30);
    rd(3'd2, d); chk("R11 write clear masks only enabled bits", d, 32'h20);
    wr(3'd4, 32'h10);
    wr(3'd2, 32'h10);
    pulse(32'h10);
    repeat (3) @(negedge clk);
    chk("R8 line high in legacy", {31'd0, line_irq}, 32'd1);
    rd(3'd0, d); chk("R11 auto-clear inactive in legacy", d, 32'h10);

    // message mode
    @(negedge clk);
    msg_mode = 1'b1;
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd4, 32'h1);
    wr(3'd5, 32'h2);
    wr(3'd2, 32'h3);
    pulse(32'h3);
    @(negedge clk);
    chk("R7 vec pulse one cycle after pending", vec_irq, 32'h3);
    chk("R7 line low in message mode", {31'd0, line_irq}, '0);
    @(negedge clk);
    chk("R7 vec pulse lasts one cycle", vec_irq, '0);
    rd(3'd0, d); chk("R9 auto-clear drops only enabled cause", d, 32'h2);
    rd(3'd2, d); chk("R10 auto-mask drops only enabled mask", d, 32'h1);
    rd(3'd4, d); chk("R9 auto-clear enable readback", d, 32'h1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      @(negedge clk);
      evt = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom) : '0;
      bus_wr = 1'b0; bus_rd = 1'b0;
      op = $urandom % 6;
      if (op == 1 || op == 2) begin
        bus_wr = 1'b1; bus_addr = 3'($urandom % 6);
        bus_wdata = ($urandom % 2) ? $urandom : ($urandom & $urandom);
      end else if (op == 3) begin
        bus_rd = 1'b1; bus_addr = 3'($urandom % 8);
      end
      if ($urandom % 150 == 0) msg_mode = ~msg_mode;
    end
    @(negedge clk);
    evt = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule